// File: doc/BRIEF.md
# Programmable 16-bit root counter

One timer channel. It holds a 16-bit count, a 16-bit compare value and a 16-bit mode word, and all three sit behind a small synchronous register port. On every qualifying tick the count advances by one. The block detects two events: the count reaching the compare value, and the count wrapping past 0xFFFF. Each event sets a sticky flag in the mode word and can raise a one-cycle interrupt pulse.

The `CHAN` parameter picks how ticks are decoded.
- With `CHAN` = 2, a mode bit can stop counting, and another mode bit can slow counting to one tick per eight clocks.
- With any other `CHAN` value, a mode bit switches the channel to count cycles in which the `ext_tick` strobe is high, for example a dot-clock or line-sync pulse.

A second mode bit chooses whether the count returns to zero on a compare match or runs freely to overflow. A third chooses between one-shot and repeating interrupts.

Top module: `rc_root_counter`

## Requirements
- R1: A write to address 0 loads the count with the low 16 bits of `wdata`. A later read of address 0 returns the count, zero-extended.
- R2: A write to address 1 sets the count to zero. It stores `wdata` bits 0..9 as the mode word and clears mode bits 10..15.
- R3: Free-run behaviour applies when mode bit 3 is clear. The count passes the compare value and wraps from 0xFFFF to 0. The wrap sets mode bit 12. A tick whose incremented count equals the compare value (address 2) sets mode bit 11.
- R4: When mode bit 3 is set, a tick whose incremented count equals the compare value loads zero instead, and mode bit 11 is set.
- R5: Mode bit 10 is set by every match or wrap event. It stays set until the next mode write.
- R6: A read of address 1 returns the mode word as it was before that clock edge. Afterwards bits 11 and 12 are cleared, unless an event on the same tick sets them again. Bits 13..15 always read as zero.
- R7: `irq` is high for exactly the one clock after a tick that produces an enabled event. Mode bit 4 enables match events and mode bit 5 enables wrap events. A match and a wrap on the same tick give one pulse.
- R8: When mode bit 6 is clear, only the first enabled event after a mode write pulses `irq`. When bit 6 is set, every enabled event pulses `irq`.
- R9: A write to address 2 leaves the count unchanged. Later match detection uses the new compare value.
- R10: With `CHAN` = 2:
  - mode bit 0 stops counting;
  - otherwise, mode bit 9 gives one tick every 8 clocks, the first on the 8th clock edge after the mode write;
  - otherwise, the count ticks on every clock.
  With any other `CHAN`, mode bit 8 makes the count tick only in cycles where `ext_tick` is high; otherwise it ticks every clock.
- R11: `rdata` is registered. It changes only on the clock edge that samples `rd_en`, and then holds. Reading address 3 returns zero. A count or mode write in a cycle overrides that cycle's tick, and that tick produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 count, 1 mode, 2 compare |
| wdata | input | DATA_W | Write data |
| ext_tick | input | 1 | External count strobe (used when `CHAN` != 2) |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench runs two channels, one with each tick decoding, against a behavioural model that is checked every clock.

It targets the following corner cases:
- **Compare value of zero with reset-at-match on.** Here match and wrap land on the same tick. A design that pulsed twice or dropped the wrap flag would diverge from the model on `irq` or on the next mode read.
- **One-shot re-arming.** A design that failed to re-arm on a mode write would stay silent after the second mode write.
- **Changing the compare value below the current count.** A design that reset the count on a compare write, or latched the old comparison, would report a stray match.
- **Divide-by-8 phase after a mode write.** An off-by-one prescaler would shift every later count read.
- **Mode read that clears the flags.** A design that cleared before returning the value would read back zeros in bits 11 and 12.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int MB_HALT    = 0;
  localparam int MB_WRAP    = 3;
  localparam int MB_IRQ_TGT = 4;
  localparam int MB_IRQ_OVF = 5;
  localparam int MB_REPEAT  = 6;
  localparam int MB_EXT     = 8;
  localparam int MB_DIV     = 9;
  localparam int MB_EVT     = 10;
  localparam int MB_HIT     = 11;
  localparam int MB_OVF     = 12;
  localparam int MODE_W     = 16;
  localparam int MODE_WR_W  = 10;

  typedef enum logic [1:0] {
    RA_COUNT  = 2'd0,
    RA_MODE   = 2'd1,
    RA_TARGET = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/rc_tick_sel.sv
module rc_tick_sel #(
  parameter int CHAN  = 2,
  parameter int PRE_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic halt_bit,
  input  logic div_bit,
  input  logic ext_bit,
  input  logic ext_tick,
  output logic tick
);
  generate
    if (CHAN == 2) begin : g_div
      logic [PRE_W-1:0] pre_q;
      logic unused_ext;
      assign unused_ext = ext_bit ^ ext_tick;
      always_ff @(posedge clk) begin
        if (rst || restart) pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
      end
      assign tick = !halt_bit && (div_bit ? (&pre_q) : 1'b1);

      // R10: a halted channel never ticks
      AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        halt_bit |-> !tick);  // R10
    end else begin : g_ext
      logic unused_div;
      assign unused_div = halt_bit ^ div_bit ^ restart ^ clk ^ rst;
      assign tick = ext_bit ? ext_tick : 1'b1;
    end
  endgenerate
endmodule

// File: rtl/rc_counter.sv
module rc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         wrap_at_tgt,
  input  logic [W-1:0] target,
  output logic [W-1:0] count,
  output logic         hit,
  output logic         ovf
);
  logic [W:0] inc;
  logic       adv;

  assign inc = {1'b0, count} + 1'b1;
  assign adv = tick && !clear && !load;
  assign ovf = adv && inc[W];
  assign hit = adv && (inc[W-1:0] == target);

  always_ff @(posedge clk) begin
    if (rst)                         count <= '0;
    else if (clear)                  count <= '0;
    else if (load)                   count <= load_val;
    else if (adv) begin
      if (ovf || (hit && wrap_at_tgt)) count <= '0;
      else                             count <= inc[W-1:0];
    end
  end

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count == '0));  // R2
  AST_WRAP_AT_TARGET: assert property (@(posedge clk) disable iff (rst)
    (hit && wrap_at_tgt) |=> (count == '0));  // R4
  AST_NO_STEP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clear && !load) |=> $stable(count));  // R10
endmodule

// File: rtl/rc_root_counter.sv
module rc_root_counter #(
  parameter int CHAN   = 2,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ext_tick,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  import rc_pkg::*;

  localparam int PAD_W = DATA_W - CNT_W;
  localparam int MPAD  = DATA_W - MODE_W;

  logic [MODE_W-1:0] mode_q, mode_n;
  logic [CNT_W-1:0]  target_q, count;
  logic              mode_wr, cnt_wr, tgt_wr, mode_rd;
  logic              tick, hit, ovf, fire, irq_n, shot_used;
  logic              unused_wdata;

  assign mode_wr = wr_en && (addr == RA_MODE);
  assign cnt_wr  = wr_en && (addr == RA_COUNT);
  assign tgt_wr  = wr_en && (addr == RA_TARGET);
  assign mode_rd = rd_en && (addr == RA_MODE);
  assign unused_wdata = ^wdata[DATA_W-1:CNT_W];

  rc_tick_sel #(.CHAN(CHAN), .PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst(rst), .restart(mode_wr),
    .halt_bit(mode_q[MB_HALT]), .div_bit(mode_q[MB_DIV]),
    .ext_bit(mode_q[MB_EXT]), .ext_tick(ext_tick), .tick(tick)
  );

  rc_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .clear(mode_wr), .load(cnt_wr),
    .load_val(wdata[CNT_W-1:0]), .wrap_at_tgt(mode_q[MB_WRAP]),
    .target(target_q), .count(count), .hit(hit), .ovf(ovf)
  );

  always_comb begin
    mode_n = mode_q;
    if (mode_rd) begin
      mode_n[MB_HIT] = 1'b0;
      mode_n[MB_OVF] = 1'b0;
    end
    if (hit) begin
      mode_n[MB_HIT] = 1'b1;
      mode_n[MB_EVT] = 1'b1;
    end
    if (ovf) begin
      mode_n[MB_OVF] = 1'b1;
      mode_n[MB_EVT] = 1'b1;
    end
    if (mode_wr) mode_n = {{(MODE_W-MODE_WR_W){1'b0}}, wdata[MODE_WR_W-1:0]};
  end

  assign fire  = (hit && mode_q[MB_IRQ_TGT]) || (ovf && mode_q[MB_IRQ_OVF]);
  assign irq_n = fire && (mode_q[MB_REPEAT] || !shot_used);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      target_q  <= '0;
      irq       <= 1'b0;
      shot_used <= 1'b0;
      rdata     <= '0;
    end else begin
      mode_q <= mode_n;
      if (tgt_wr) target_q <= wdata[CNT_W-1:0];
      irq <= irq_n;
      if (mode_wr)    shot_used <= 1'b0;
      else if (irq_n) shot_used <= 1'b1;
      if (rd_en) begin
        case (reg_addr_e'(addr))
          RA_COUNT:  rdata <= {{PAD_W{1'b0}}, count};
          RA_MODE:   rdata <= {{MPAD{1'b0}}, mode_q};
          RA_TARGET: rdata <= {{PAD_W{1'b0}}, target_q};
          default:   rdata <= '0;
        endcase
      end
    end
  end

  AST_MODE_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == RA_MODE) |=> (rdata[15:13] == 3'b000));  // R6
  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (mode_rd && !mode_wr && !hit && !ovf) |=> (!mode_q[MB_HIT] && !mode_q[MB_OVF]));  // R6
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (shot_used && !mode_q[MB_REPEAT] && !mode_wr) |=> !irq);  // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(hit || ovf));  // R7
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (irq && !$past(hit || ovf, 1)) |-> 1'b0);  // R7
  AST_TGT_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (tgt_wr && !cnt_wr && !mode_wr && !tick) |=> $stable(count));  // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));  // R11
endmodule

// File: tb/rc_root_counter_test.sv
module rc_root_counter_test;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0, ext_tick = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata_a, rdata_b;
  logic          irq_a, irq_b;

  int total = 0, bad = 0, cyc = 0;
  string phase = "R11";

  // model state: index 0 = divided-clock channel, index 1 = strobe channel
  int m_cnt[2], m_mode[2], m_tgt[2], m_pre[2], m_rd[2];
  bit m_done[2], m_irq[2];

  always #2 clk = ~clk;

  rc_root_counter #(.CHAN(2), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ext_tick(ext_tick), .rdata(rdata_a), .irq(irq_a));

  rc_root_counter #(.CHAN(0), .DATA_W(DW)) uut_x (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ext_tick(ext_tick), .rdata(rdata_b), .irq(irq_b));

  task automatic step(int k);
    bit mw, cw, tw, tk, adv, hit, ovf, fire, fired;
    int inc, md;
    md = m_mode[k];
    mw = wr_en && addr == 2'd1;
    cw = wr_en && addr == 2'd0;
    tw = wr_en && addr == 2'd2;
    if (rd_en) m_rd[k] = (addr == 2'd0) ? m_cnt[k] : (addr == 2'd1) ? md :
                         (addr == 2'd2) ? m_tgt[k] : 0;
    if (k == 0) tk = md[0] ? 1'b0 : (md[9] ? (m_pre[k] == 7) : 1'b1);
    else        tk = md[8] ? ext_tick : 1'b1;
    adv = tk && !mw && !cw;
    inc = m_cnt[k] + 1;
    ovf = adv && (inc == 65536);
    hit = adv && ((inc % 65536) == m_tgt[k]);
    fire  = (hit && md[4]) || (ovf && md[5]);
    fired = fire && (md[6] || !m_done[k]);
    m_irq[k] = fired;
    if (fired) m_done[k] = 1'b1;
    if (rd_en && addr == 2'd1) m_mode[k] = m_mode[k] & ~(3 << 11);
    if (hit) m_mode[k] = m_mode[k] | (1 << 11) | (1 << 10);
    if (ovf) m_mode[k] = m_mode[k] | (1 << 12) | (1 << 10);
    if (mw)       m_cnt[k] = 0;
    else if (cw)  m_cnt[k] = int'(wdata & 32'hFFFF);
    else if (adv) m_cnt[k] = (ovf || (hit && md[3])) ? 0 : inc;
    if (tw) m_tgt[k] = int'(wdata & 32'hFFFF);
    m_pre[k] = mw ? 0 : (m_pre[k] + 1) % 8;
    if (mw) begin
      m_mode[k] = int'(wdata & 32'h3FF);
      m_done[k] = 1'b0;
    end
  endtask

  task automatic check(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", phase, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int k = 0; k < 2; k++) begin
        m_cnt[k] = 0; m_mode[k] = 0; m_tgt[k] = 0; m_pre[k] = 0;
        m_rd[k] = 0; m_done[k] = 0; m_irq[k] = 0;
      end
    end else begin
      step(0);
      step(1);
    end
    #1;
    check("irq div-channel", int'(irq_a), int'(m_irq[0]));
    check("irq strobe-channel", int'(irq_b), int'(m_irq[1]));
    check("rdata div-channel", int'(rdata_a), m_rd[0]);
    check("rdata strobe-channel", int'(rdata_b), m_rd[1]);
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 2'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(int a);
    @(negedge clk); rd_en = 1'b1; addr = 2'(a);
    @(negedge clk); rd_en = 1'b0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic strobe(int n);
    repeat (n) begin
      @(negedge clk); ext_tick = 1'b1;
      @(negedge clk); ext_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    phase = "R11"; idle(2); rd(0); rd(1); rd(2); rd(3);
    phase = "R1";  wr(0, 32'hABCD_1234); rd(0);
    phase = "R2";  wr(1, 32'h0000_FFFF); rd(1); rd(0); idle(3); rd(0);
    phase = "R3";  wr(2, 5); wr(1, 32'h30); idle(10); rd(1);
                   wr(0, 32'hFFFA); idle(10); rd(1); rd(0);
    phase = "R6";  rd(1); rd(1);
    phase = "R4";  wr(2, 3); wr(1, 32'h58); idle(12); rd(0); rd(1);
    phase = "R8";  wr(1, 32'h18); idle(12); wr(1, 32'h18); idle(6);
    phase = "R7";  wr(2, 0); wr(1, 32'h38); wr(0, 32'hFFFD); idle(6); rd(1);
    phase = "R9";  wr(2, 32'h40); wr(1, 32'h10); idle(5); wr(2, 8); idle(8); rd(0);
                   wr(2, 2); idle(4); rd(1); rd(2);
    phase = "R10"; wr(1, 32'h210); wr(2, 3); idle(40); rd(0);
                   wr(1, 32'h1); idle(5); rd(0);
                   wr(1, 32'h110); strobe(6); rd(0); idle(3); rd(0);
    phase = "R5";  rd(1); rd(1);
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule